// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is a single channel of a free-running timer. It shares the timer's count value and count-advance tick with its sibling channels and is switched between two jobs by a mode bit. In capture mode it watches an external pin, synchronizes it, detects the chosen transition and stores the current count in its channel register, raising the channel flag. In compare mode the same register holds a target count; when the count advances onto that target, the flag is raised and the output pin is set, cleared or inverted as configured.

A one-cycle force strobe applies the configured pin action at once, without waiting for a match and without touching the flag. The flag is cleared by a one-cycle clear strobe, and an interrupt request is raised while the flag and the enable bit are both set. The channel register can be loaded directly so that compare targets can be placed.

Top module: `cmpcap_chan`

## Requirements
- R1: After reset the channel register reads 0, the flag is 0, the output pin is 0 and the interrupt request is 0.
- R2: In capture mode (`mode_i`=0) the edge field `edge_sel_i` selects 01 rising, 10 falling, 11 both; a selected transition on `pin_i` stores `cnt_i` into the register and sets the flag on the third rising clock edge after the pin changes (two synchronizer flops plus one edge stage).
- R3: With `edge_sel_i`=00, or on a transition of the unselected polarity, the register and the flag are left unchanged.
- R4: In compare mode (`mode_i`=1) pin transitions do not change the register or the flag.
- R5: In compare mode, a clock edge with `tick_i`=1 and `cnt_i` equal to the register sets the flag; equality without `tick_i` has no effect.
- R6: The action field `act_sel_i` gives the pin result of a match: 01 inverts `pin_o`, 10 drives it 0, 11 drives it 1, 00 leaves it unchanged while the flag is still set.
- R7: In compare mode, `force_i` applies the configured action on the edge where it is sampled without any match and does not set the flag; in capture mode it has no effect.
- R8: A force and a match in the same cycle apply the action once (a toggle inverts the pin a single time) and set the flag.
- R9: `irq_o` is 1 exactly when the flag and `irq_en_i` are both 1.
- R10: `flag_clr_i` clears the flag on the next edge; if the flag is set by an event in the same cycle, setting wins.
- R11: `wr_en_i` loads `wr_data_i` into the register; a capture in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | W | Shared timer count |
| tick_i | input | 1 | Count-advance qualifier for compare |
| mode_i | input | 1 | 1 compare, 0 capture |
| edge_sel_i | input | 2 | Capture edge selection |
| act_sel_i | input | 2 | Pin action on compare or force |
| irq_en_i | input | 1 | Interrupt enable |
| force_i | input | 1 | Forced-compare strobe |
| flag_clr_i | input | 1 | Flag clear strobe |
| wr_en_i | input | 1 | Register load strobe |
| wr_data_i | input | W | Register load value |
| pin_i | input | 1 | Capture input pin |
| pin_o | output | 1 | Compare output pin |
| chan_o | output | W | Channel register value |
| flag_o | output | 1 | Channel event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two collisions are provoked deliberately. A force strobe is raised in the very cycle where a ticked count equals the target with the toggle action, and the bench judges that the pin flips exactly once relative to its prior level while the flag rises. A flag clear is presented in the same cycle as a compare match, and the flag must read 1 afterwards, since setting has priority over clearing.

// File: rtl/cmpcap_pkg.sv
package cmpcap_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } act_sel_e;

endpackage

// File: rtl/cmpcap_edge.sv
module cmpcap_edge #(
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] edge_sel_i,
    output logic       hit_o
);
    import cmpcap_pkg::*;

    localparam int DEPTH = SYNC + 1;

    logic [DEPTH-1:0] sh_d, sh_q;
    logic             rise, fall;

    generate
        if (DEPTH > 1) begin : g_chain
            always_comb sh_d = {sh_q[DEPTH-2:0], pin_i};
        end else begin : g_single
            always_comb sh_d = pin_i;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    always_comb begin
        rise = sh_q[SYNC-1] & ~sh_q[SYNC];
        fall = ~sh_q[SYNC-1] & sh_q[SYNC];
        unique case (edge_sel_e'(edge_sel_i))
            EDGE_RISE: hit_o = rise;
            EDGE_FALL: hit_o = fall;
            EDGE_ANY:  hit_o = rise | fall;
            default:   hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmpcap_action.sv
module cmpcap_action (
    input  logic       fire_i,
    input  logic [1:0] act_sel_i,
    input  logic       pin_q_i,
    output logic       pin_d_o
);
    import cmpcap_pkg::*;

    always_comb begin
        pin_d_o = pin_q_i;
        if (fire_i) begin
            unique case (act_sel_e'(act_sel_i))
                ACT_TOGGLE: pin_d_o = ~pin_q_i;
                ACT_LOW:    pin_d_o = 1'b0;
                ACT_HIGH:   pin_d_o = 1'b1;
                default:    pin_d_o = pin_q_i;
            endcase
        end
    end

endmodule

// File: rtl/cmpcap_chan.sv
module cmpcap_chan #(
    parameter int W    = 16,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic         tick_i,
    input  logic         mode_i,
    input  logic [1:0]   edge_sel_i,
    input  logic [1:0]   act_sel_i,
    input  logic         irq_en_i,
    input  logic         force_i,
    input  logic         flag_clr_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         pin_i,
    output logic         pin_o,
    output logic [W-1:0] chan_o,
    output logic         flag_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [W-1:0] val;
        logic         flag;
        logic         pin;
    } state_t;

    state_t state_d, state_q;

    logic edge_hit;
    logic cap_ev;
    logic match_ev;
    logic fire;
    logic pin_next;

    cmpcap_edge #(.SYNC(SYNC)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .edge_sel_i (edge_sel_i),
        .hit_o      (edge_hit)
    );

    always_comb begin
        cap_ev   = ~mode_i & edge_hit;
        match_ev = mode_i & tick_i & (cnt_i == state_q.val);
        fire     = match_ev | (mode_i & force_i);
    end

    cmpcap_action u_act (
        .fire_i    (fire),
        .act_sel_i (act_sel_i),
        .pin_q_i   (state_q.pin),
        .pin_d_o   (pin_next)
    );

    always_comb begin
        state_d = state_q;
        if (cap_ev)       state_d.val = cnt_i;
        else if (wr_en_i) state_d.val = wr_data_i;
        if (cap_ev | match_ev) state_d.flag = 1'b1;
        else if (flag_clr_i)   state_d.flag = 1'b0;
        state_d.pin = pin_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pin_o  = state_q.pin;
    assign chan_o = state_q.val;
    assign flag_o = state_q.flag;
    assign irq_o  = state_q.flag & irq_en_i;

endmodule

// File: rtl/cmpcap_chan_chk.sv
module cmpcap_chan_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt_i,
    input logic         tick_i,
    input logic         mode_i,
    input logic [1:0]   edge_sel_i,
    input logic [1:0]   act_sel_i,
    input logic         irq_en_i,
    input logic         force_i,
    input logic         flag_clr_i,
    input logic         wr_en_i,
    input logic         pin_o,
    input logic [W-1:0] chan_o,
    input logic         flag_o,
    input logic         irq_o
);

    // R9
    no_irq_without_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_o |-> !irq_o);

    // R5
    match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && tick_i && cnt_i == chan_o) |=> flag_o);

    // R6
    match_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && tick_i && cnt_i == chan_o && act_sel_i == 2'b11) |=> pin_o);

    // R6
    match_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && tick_i && cnt_i == chan_o && act_sel_i == 2'b10) |=> !pin_o);

    // R7
    force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && force_i && !flag_o && !(tick_i && cnt_i == chan_o)) |=> !flag_o);

    // R3
    capture_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && edge_sel_i == 2'b00 && !wr_en_i) |=> $stable(chan_o));

    // R4
    compare_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !wr_en_i) |=> $stable(chan_o));

    // R7
    capture_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> $stable(pin_o));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !mode_i && edge_sel_i == 2'b00) |=> !flag_o);

endmodule

bind cmpcap_chan cmpcap_chan_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_i      (cnt_i),
    .tick_i     (tick_i),
    .mode_i     (mode_i),
    .edge_sel_i (edge_sel_i),
    .act_sel_i  (act_sel_i),
    .irq_en_i   (irq_en_i),
    .force_i    (force_i),
    .flag_clr_i (flag_clr_i),
    .wr_en_i    (wr_en_i),
    .pin_o      (pin_o),
    .chan_o     (chan_o),
    .flag_o     (flag_o),
    .irq_o      (irq_o)
);

// File: tb/cmpcap_chan_test.sv
module cmpcap_chan_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_i = '0;
    logic         tick_i = 1'b0;
    logic         mode_i = 1'b0;
    logic [1:0]   edge_sel_i = 2'b00;
    logic [1:0]   act_sel_i = 2'b00;
    logic         irq_en_i = 1'b0;
    logic         force_i = 1'b0;
    logic         flag_clr_i = 1'b0;
    logic         wr_en_i = 1'b0;
    logic [W-1:0] wr_data_i = '0;
    logic         pin_i = 1'b0;
    logic         pin_o;
    logic [W-1:0] chan_o;
    logic         flag_o;
    logic         irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmpcap_chan #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .tick_i(tick_i),
        .mode_i(mode_i), .edge_sel_i(edge_sel_i), .act_sel_i(act_sel_i),
        .irq_en_i(irq_en_i), .force_i(force_i), .flag_clr_i(flag_clr_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .pin_i(pin_i),
        .pin_o(pin_o), .chan_o(chan_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input logic [W-1:0] v);
        wr_data_i = v; wr_en_i = 1'b1; cyc(1); wr_en_i = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr_i = 1'b1; cyc(1); flag_clr_i = 1'b0;
    endtask

    task automatic set_pin_level(input logic lvl);
        act_sel_i = lvl ? 2'b11 : 2'b10;
        force_i = 1'b1; cyc(1); force_i = 1'b0;
    endtask

    initial begin
        cyc(3);
        // R1 reset state
        chk("R1 chan", chan_o, '0);
        chk("R1 flag", {15'd0, flag_o}, 16'd0);
        chk("R1 pin", {15'd0, pin_o}, 16'd0);
        chk("R1 irq", {15'd0, irq_o}, 16'd0);
        rst_n = 1'b1;
        cyc(2);

        // R2 / R3 sweep: every edge field x both transition directions
        mode_i = 1'b0;
        for (int e = 0; e < 4; e++) begin
            for (int d = 0; d < 2; d++) begin
                logic         lvl_new;
                logic         take;
                logic [W-1:0] pre, cv;
                lvl_new = (d == 0);
                pre = 16'h1000 + 16'(e * 16 + d);
                cv  = 16'hA000 + 16'(e * 256 + d * 17);
                edge_sel_i = 2'b00;
                pin_i = ~lvl_new;
                cyc(5);
                load(pre);
                clr_flag();
                edge_sel_i = 2'(e);
                cnt_i = cv;
                take = (e == 3) || (e == 1 && lvl_new) || (e == 2 && !lvl_new);
                pin_i = lvl_new;
                cyc(2);
                chk(take ? "R2 not yet" : "R3 not yet", chan_o, pre);
                cyc(1);
                chk(take ? "R2 latch" : "R3 hold", chan_o, take ? cv : pre);
                chk(take ? "R2 flag" : "R3 flag", {15'd0, flag_o}, {15'd0, take});
                cyc(2);
            end
        end

        // R9 irq gating
        irq_en_i = 1'b0; cyc(1);
        chk("R9 irq off", {15'd0, irq_o}, {15'd0, 1'b0});
        irq_en_i = 1'b1; cyc(1);
        chk("R9 irq on", {15'd0, irq_o}, {15'd0, flag_o});
        clr_flag();
        chk("R10 clear", {15'd0, flag_o}, 16'd0);
        chk("R9 irq cleared", {15'd0, irq_o}, 16'd0);

        // R11 write collides with capture: capture wins
        edge_sel_i = 2'b01; pin_i = 1'b0; cyc(5);
        cnt_i = 16'h5A5A; pin_i = 1'b1; cyc(2);
        wr_data_i = 16'h1234; wr_en_i = 1'b1; cyc(1); wr_en_i = 1'b0;
        chk("R11 capture wins", chan_o, 16'h5A5A);
        load(16'h00C3);
        chk("R11 load", chan_o, 16'h00C3);
        clr_flag();

        // R7 force ignored in capture mode
        act_sel_i = 2'b11; force_i = 1'b1; cyc(1); force_i = 1'b0;
        chk("R7 capture force", {15'd0, pin_o}, 16'd0);

        // R4 compare mode ignores pin transitions
        mode_i = 1'b1; edge_sel_i = 2'b11; tick_i = 1'b0;
        cnt_i = 16'h0001;
        pin_i = 1'b0; cyc(5);
        chk("R4 reg", chan_o, 16'h00C3);
        chk("R4 flag", {15'd0, flag_o}, 16'd0);

        // R5 / R6 sweep: every action x both starting levels
        for (int a = 0; a < 4; a++) begin
            for (int s = 0; s < 2; s++) begin
                logic [W-1:0] tgt;
                logic         expp;
                tgt = 16'h0300 + 16'(a * 2 + s);
                set_pin_level(s[0]);
                load(tgt);
                clr_flag();
                act_sel_i = 2'(a);
                cnt_i = tgt; tick_i = 1'b0; cyc(1);
                chk("R5 no tick flag", {15'd0, flag_o}, 16'd0);
                chk("R5 no tick pin", {15'd0, pin_o}, {15'd0, s[0]});
                tick_i = 1'b1; cyc(1); tick_i = 1'b0;
                case (a)
                    1: expp = ~s[0];
                    2: expp = 1'b0;
                    3: expp = 1'b1;
                    default: expp = s[0];
                endcase
                chk("R5 match flag", {15'd0, flag_o}, 16'd1);
                chk("R6 match pin", {15'd0, pin_o}, {15'd0, expp});
                cnt_i = tgt + 16'd1; tick_i = 1'b1; cyc(1); tick_i = 1'b0;
                chk("R6 past target pin", {15'd0, pin_o}, {15'd0, expp});
            end
        end

        // R7 force without match: action applied, no flag
        for (int a = 1; a < 4; a++) begin
            logic expp;
            set_pin_level(1'b1);
            clr_flag();
            cnt_i = 16'h7777; load(16'h0001);
            act_sel_i = 2'(a);
            force_i = 1'b1; cyc(1); force_i = 1'b0;
            expp = (a == 3);
            chk("R7 force pin", {15'd0, pin_o}, {15'd0, expp});
            chk("R7 force flag", {15'd0, flag_o}, 16'd0);
        end

        // R8 force and match together with toggle
        set_pin_level(1'b0);
        clr_flag();
        load(16'h4444);
        act_sel_i = 2'b01; cnt_i = 16'h4444; tick_i = 1'b1; force_i = 1'b1;
        cyc(1);
        tick_i = 1'b0; force_i = 1'b0;
        chk("R8 single toggle", {15'd0, pin_o}, 16'd1);
        chk("R8 flag", {15'd0, flag_o}, 16'd1);

        // R10 clear collides with match: set wins
        clr_flag();
        act_sel_i = 2'b00; tick_i = 1'b1; flag_clr_i = 1'b1;
        cyc(1);
        tick_i = 1'b0; flag_clr_i = 1'b0;
        chk("R10 set wins", {15'd0, flag_o}, 16'd1);

        // R5 running count: flag rises exactly when count reaches target
        clr_flag();
        load(16'd40);
        for (int c = 30; c < 45; c++) begin
            cnt_i = 16'(c); tick_i = 1'b1; cyc(1);
            chk("R5 sweep", {15'd0, flag_o}, {15'd0, c >= 40});
        end
        tick_i = 1'b0;

        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule